// File: doc/BRIEF.md
# Buffered Serial Character Reader

This block sits behind an FSK demodulator and frames the asynchronous 1200-baud character stream that the demodulator recovers. For each character it drops the start bit and keeps the eight data bits and the trailing stop bit. In the middle of the stop bit it copies all nine bits at once into an output shift register, then pulls a ready strobe low to tell the host that a character is waiting.

The host reads the character through a read clock that it drives itself. That clock need not relate to the system clock in any way. Each rising edge of the read clock moves the serial output on by one bit, in the order the bits arrived on the line. The stop bit comes ninth, so the host can test it for a framing error. A host that does not care about framing errors can stop after eight edges.

The ready strobe stays low for half a bit time. If the host starts reading while the strobe is still low, the strobe ends at the first read edge. A qualified-carrier input gates the block. With no carrier, no character is framed or loaded, and the ready strobe stays high.

Top module: `fsk_byte_reader`

## Requirements
- R1: A character begins on a high-to-low transition of `rx_bit`. The low level is checked again half a bit time (`BIT_CYCLES/2` clocks) later. If the line has returned high by then, no character is framed and nothing is loaded.
- R2: In the middle of the stop bit, the nine kept bits are loaded into the output register. `rdy_n` goes low on the clock edge after the stop bit is sampled.
- R3: After a load, `ser_data` shows data bit 0 (the first data bit received) before any `host_clk` edge.
- R4: Each rising edge of `host_clk` moves the register on by one place. `ser_data` then shows data bits 1 to 7 and then the stop bit. A 1 is shifted in behind the bits, so after nine edges `ser_data` reads 1.
- R5: A `host_clk` rising edge seen while `rdy_n` is low sets `rdy_n` high again right away.
- R6: With no read edge, `rdy_n` stays low for exactly `BIT_CYCLES/2` clocks and then returns high.
- R7: While `carrier_ok` is low, no character is loaded, `rdy_n` stays high, and the held contents stay on `ser_data`.
- R8: A new load replaces any contents that the host has not read.
- R9: If the host reads only 8 bits and skips the stop bit, the next character still loads and reads back correctly.
- R10: A stop bit received as 0 is kept and appears on `ser_data` after the eighth read edge. This marks a framing error.
- R11: `host_clk` passes through a synchronizer. A level held high moves the register on by exactly one place, and the bit shown changes within `SYNC_STAGES+1` clocks of the rising edge.
- R12: After reset, `rdy_n` is 1 and `ser_data` is 1 (the register is filled with ones).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Demodulated bit stream, synchronous to `clk`; 1 = mark |
| carrier_ok | input | 1 | High while a qualified carrier is present |
| host_clk | input | 1 | Read clock from the host, asynchronous to `clk` |
| ser_data | output | 1 | Serial output, current bit of the register |
| rdy_n | output | 1 | Active-low strobe: a character has been loaded |

## Verification
The hardest case to reach is a host read edge that arrives while the ready strobe is still low. The strobe lasts only half a bit time, and its end must come from the read edge rather than from the timer running out. The bench therefore splits character transmission into two tasks. It stops partway through the stop bit and toggles `host_clk` at once. It then checks that `rdy_n` is high well before the timer would have expired and that the second data bit is on `ser_data`. The line is then driven on to finish the character. The carrier gate is reached the same way. A character is left unread in the register, `carrier_ok` is dropped, a second character is sent, and the bench confirms at the port that the first character's bits are still there.

// File: rtl/fbr_pkg.sv
// Shared definitions for the buffered serial character reader.
package fbr_pkg;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 1;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } fr_state_e;
endpackage

// File: rtl/fbr_framer.sv
// Character framer: finds a start edge, checks it at mid-start, and
// samples each data bit and the stop bit at the middle of its cell.
// Assumes rx_bit is already synchronous to clk and that BIT_CYCLES >= 4.
// Emits a one-cycle load pulse with {stop, data[7:0]} at mid-stop.
module fbr_framer
    import fbr_pkg::*;
#(
    parameter int BIT_CYCLES = 6667
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_bit,
    input  logic                  carrier_ok,
    output logic                  ld_o,
    output logic [FRAME_BITS-1:0] frame_o
);
    localparam int CW = $clog2(BIT_CYCLES + 1);
    localparam int IW = $clog2(DATA_BITS + 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(BIT_CYCLES / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(BIT_CYCLES - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

    fr_state_e            st_q;
    logic [CW-1:0]        cnt_q;
    logic [IW-1:0]        idx_q;
    logic                 rx_q;
    logic [DATA_BITS-1:0] sh_q;

    // Frame state machine, bit timing and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= FR_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            rx_q    <= 1'b1;
            sh_q    <= '0;
            ld_o    <= 1'b0;
            frame_o <= '1;
        end else begin
            ld_o <= 1'b0;
            rx_q <= rx_bit;
            if (!carrier_ok) begin
                st_q  <= FR_IDLE;
                cnt_q <= '0;
                idx_q <= '0;
            end else begin
                case (st_q)
                    FR_IDLE: begin
                        if (rx_q && !rx_bit) begin
                            st_q  <= FR_START;
                            cnt_q <= '0;
                        end
                    end
                    FR_START: begin
                        if (cnt_q == HALF_LAST) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            st_q  <= rx_bit ? FR_IDLE : FR_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_DATA: begin
                        if (cnt_q == FULL_LAST) begin
                            cnt_q <= '0;
                            sh_q  <= {rx_bit, sh_q[DATA_BITS-1:1]};
                            if (idx_q == IDX_LAST) st_q  <= FR_STOP;
                            else                   idx_q <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    FR_STOP: begin
                        if (cnt_q == FULL_LAST) begin
                            cnt_q   <= '0;
                            ld_o    <= 1'b1;
                            frame_o <= {rx_bit, sh_q};
                            st_q    <= FR_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: st_q <= FR_IDLE;
                endcase
            end
        end
    end

    // R1
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FR_START && cnt_q == HALF_LAST && rx_bit && carrier_ok) |=> st_q == FR_IDLE);

    // R2
    load_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_o |-> $past(st_q) == FR_STOP);

    // R7
    no_load_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_ok |=> !ld_o);
endmodule

// File: rtl/fbr_edge_sync.sv
// Synchronizes the asynchronous host read clock into clk and
// produces a one-cycle pulse for each rising edge.
// Assumes host_clk stays high and low for at least SYNC_STAGES+1 clocks each.
module fbr_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [SYNC_STAGES:0] s_q;

    // Synchronizer chain with one extra stage kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-1:0], async_i};
    end

    assign rise_o = s_q[SYNC_STAGES-1] & ~s_q[SYNC_STAGES];

    // R11
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/fbr_out_reg.sv
// Nine-bit output register and ready strobe. Loads on the framer pulse,
// shifts toward bit 0 on each read edge and fills with ones behind.
// The ready strobe lasts HALF_CYCLES clocks unless a read edge ends it first.
// Assumes HALF_CYCLES >= 2.
module fbr_out_reg
    import fbr_pkg::*;
#(
    parameter int HALF_CYCLES = 3333
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  carrier_ok,
    input  logic                  ld_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic                  rise_i,
    output logic                  data_o,
    output logic                  rdy_n_o
);
    localparam int HW = $clog2(HALF_CYCLES + 2);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYCLES - 1);

    logic [FRAME_BITS-1:0] sreg_q;
    logic [HW-1:0]         hcnt_q;
    logic                  take;

    assign take   = ld_i & carrier_ok;
    assign data_o = sreg_q[0];

    // Parallel load of a new character, else serial shift on a read edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      sreg_q <= '1;
        else if (take)   sreg_q <= frame_i;
        else if (rise_i) sreg_q <= {1'b1, sreg_q[FRAME_BITS-1:1]};
    end

    // Ready strobe: set low on load, released by timer, read edge or carrier loss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n_o <= 1'b1;
            hcnt_q  <= '0;
        end else if (!carrier_ok) begin
            rdy_n_o <= 1'b1;
        end else if (take) begin
            rdy_n_o <= 1'b0;
            hcnt_q  <= '0;
        end else if (!rdy_n_o) begin
            if (rise_i || hcnt_q == HALF_LAST) rdy_n_o <= 1'b1;
            else                               hcnt_q  <= hcnt_q + 1'b1;
        end
    end

    // Checker-side count of consecutive cycles with the strobe low.
    logic [HW-1:0] lo_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        lo_run_q <= '0;
        else if (rdy_n_o)  lo_run_q <= '0;
        else if (take)     lo_run_q <= HW'(1);
        else               lo_run_q <= lo_run_q + 1'b1;
    end

    // R2
    rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !rdy_n_o);

    // R3
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> data_o == $past(frame_i[0]));

    // R4
    shift_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !take) |=> sreg_q == {1'b1, $past(sreg_q[FRAME_BITS-1:1])});

    // R5
    early_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n_o && rise_i && !take) |=> rdy_n_o);

    // R6
    rdy_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_run_q <= HW'(HALF_CYCLES));

    // R7
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!carrier_ok && !rise_i) |=> (rdy_n_o && $stable(sreg_q)));
endmodule

// File: rtl/fsk_byte_reader.sv
// Top level of the buffered serial character reader: framer, read-clock
// synchronizer and output register. Assumes rx_bit is synchronous to clk
// and BIT_CYCLES is the nominal bit period in clk cycles.
module fsk_byte_reader
    import fbr_pkg::*;
#(
    parameter int BIT_CYCLES  = 6667,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic carrier_ok,
    input  logic host_clk,
    output logic ser_data,
    output logic rdy_n
);
    localparam int HALF_CYCLES = BIT_CYCLES / 2;

    logic                  ld;
    logic [FRAME_BITS-1:0] frame;
    logic                  rise;

    fbr_framer #(.BIT_CYCLES(BIT_CYCLES)) i_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .carrier_ok(carrier_ok),
        .ld_o      (ld),
        .frame_o   (frame)
    );

    fbr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(host_clk),
        .rise_o (rise)
    );

    fbr_out_reg #(.HALF_CYCLES(HALF_CYCLES)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .carrier_ok(carrier_ok),
        .ld_i      (ld),
        .frame_i   (frame),
        .rise_i    (rise),
        .data_o    (ser_data),
        .rdy_n_o   (rdy_n)
    );
endmodule

// File: tb/test_fsk_byte_reader.sv
// Bench for the buffered serial character reader: a vector table of
// characters followed by directed cases for reset and corner behaviour.
module test_fsk_byte_reader;
    localparam int BIT  = 32;
    localparam int HALF = BIT / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1;
    logic carrier_ok = 1'b1;
    logic host_clk = 1'b0;
    logic ser_data;
    logic rdy_n;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    fsk_byte_reader #(.BIT_CYCLES(BIT), .SYNC_STAGES(2)) i_fsk_byte_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .carrier_ok(carrier_ok),
        .host_clk  (host_clk),
        .ser_data  (ser_data),
        .rdy_n     (rdy_n)
    );

    // Each entry is {stop, data[7:0]}.
    localparam logic [8:0] VEC [6] = '{9'h1A5, 9'h100, 9'h1FF, 9'h03C, 9'h155, 9'h081};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive start and data bits, then stop bit up to just after its middle.
    task automatic send_head(input logic [8:0] f, input logic exp_load);
        rx_bit = 1'b0;
        tick(BIT);
        for (int i = 0; i < 8; i++) begin
            rx_bit = f[i];
            tick(BIT);
        end
        rx_bit = f[8];
        tick(HALF + 4);
        check("R2", {8'd0, rdy_n}, {8'd0, !exp_load});
        if (exp_load) check("R3", {8'd0, ser_data}, {8'd0, f[0]});
    endtask

    // Finish the stop bit and leave the line at mark for two bit times.
    task automatic send_tail(input int used);
        tick(BIT - HALF - 4 - used);
        rx_bit = 1'b1;
        tick(2 * BIT);
    endtask

    // Check the shown bit, then apply one read pulse; n pulses in total.
    task automatic read_chk(input logic [8:0] f, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            check(req, {8'd0, ser_data}, {8'd0, f[i]});
            host_clk = 1'b1;
            tick(4);
            host_clk = 1'b0;
            tick(4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lows;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R12 reset state
        check("R12", {8'd0, rdy_n}, 9'd1);
        check("R12", {8'd0, ser_data}, 9'd1);
        tick(2 * BIT);

        // Table walk: R2, R3, R4, R6, R10 (entries 3 and 5 carry stop 0)
        for (int v = 0; v < 6; v++) begin
            send_head(VEC[v], 1'b1);
            send_tail(0);
            check("R6", {8'd0, rdy_n}, 9'd1);
            read_chk(VEC[v], 9, VEC[v][8] ? "R4" : "R10");
            check("R4", {8'd0, ser_data}, 9'd1);
        end

        // R5 early clear by first read edge while strobe is low
        send_head(9'h1C6, 1'b1);
        host_clk = 1'b1;
        tick(4);
        host_clk = 1'b0;
        tick(4);
        check("R5", {8'd0, rdy_n}, 9'd1);
        check("R5", {8'd0, ser_data}, {8'd0, 1'b1});
        send_tail(8);
        read_chk({1'b1, 8'hE3}, 8, "R4");

        // R8 second character overwrites unread first
        send_head(9'h133, 1'b1);
        send_tail(0);
        send_head(9'h1CA, 1'b1);
        send_tail(0);
        read_chk(9'h1CA, 9, "R8");

        // R9 partial read of 8 bits, then next character
        send_head(9'h196, 1'b1);
        send_tail(0);
        read_chk(9'h196, 8, "R9");
        send_head(9'h169, 1'b1);
        send_tail(0);
        read_chk(9'h169, 9, "R9");

        // R11 held-high read clock moves exactly one place
        send_head(9'h1B4, 1'b1);
        send_tail(0);
        host_clk = 1'b1;
        tick(3);
        check("R11", {8'd0, ser_data}, {8'd0, 1'b0});
        tick(17);
        check("R11", {8'd0, ser_data}, {8'd0, 1'b0});
        host_clk = 1'b0;
        tick(4);
        read_chk({1'b1, 8'hDA}, 8, "R11");

        // R7 carrier gating keeps held contents and strobe high
        send_head(9'h1F0, 1'b1);
        send_tail(0);
        carrier_ok = 1'b0;
        tick(4);
        send_head(9'h10F, 1'b0);
        send_tail(0);
        check("R7", {8'd0, rdy_n}, 9'd1);
        carrier_ok = 1'b1;
        tick(4);
        read_chk(9'h1F0, 9, "R7");

        // R1 short low glitch is not a start bit
        send_head(9'h0FE, 1'b1);
        send_tail(0);
        rx_bit = 1'b0;
        tick(4);
        rx_bit = 1'b1;
        lows = 0;
        for (int i = 0; i < 12 * BIT; i++) begin
            tick(1);
            if (!rdy_n) lows++;
        end
        check("R1", 9'(lows), 9'd0);
        read_chk(9'h0FE, 9, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule